// File: doc/BRIEF.md
# Battery power-mode supervisor

This block decides the power state of a small battery-backed system from a set of digital comparator flags. The flags say whether the external input supply is valid, whether the battery is above its over-discharge level and above its release level, whether a discharge overcurrent or a supply-rail short is present, and the state of a shutdown request and a wake-up input. All flags are asynchronous, and the block synchronizes each one with two flops.

The block keeps one of four modes: shutdown, input-powered, battery-powered and over-discharge-off. From the mode it chooses the feed of the system rail (input, battery or none), enables the downstream regulator, and gates the battery-measurement switch. Every time qualification is counted in ticks of an external one-millisecond strobe. An input supply must stay valid for a minimum time before it brings the system out of an off state. A wake-up pulse must be held for longer, and the battery must also be above its release level. An over-discharge condition is remembered across an input connection until the battery has recovered.

Top module: `pm_sup`

## Requirements
- R1: With the input invalid and the system battery-powered, a high shutdown request while wake-up is low moves the mode to shutdown. While the input is valid, the shutdown request has no effect.
- R2: From shutdown or over-discharge-off, a valid input held for 240 ms selects input-powered. With the input invalid, a wake-up held for 1200 ms selects battery-powered, but only when the battery is above its release level. Without that level the mode stays off.
- R3: Wake-up time is not counted while the input is valid. If the shutdown request is high when a wake-up pulse brings the system on, the system stays battery-powered only while wake-up stays high.
- R4: In battery-powered mode, a battery below the over-discharge level for 60 ms selects over-discharge-off.
- R5: A valid input held for 240 ms in over-discharge-off selects input-powered. If the input is then lost before the battery has been seen above the release level, the mode returns to over-discharge-off, even if the battery is above the over-discharge level.
- R6: In battery-powered mode, a discharge overcurrent lasting 10 ms selects shutdown, and a shorter one has no effect on the mode. A qualified input or a qualified wake-up restores the system.
- R7: In battery-powered mode, a supply-rail short selects shutdown within three clock cycles, with no deglitch.
- R8: The mode output uses these codes: 0 shutdown, 1 input-powered, 2 battery-powered, 3 over-discharge-off. The rail select uses 01 for the input, 10 for the battery and 00 for unpowered. The regulator enable is high in modes 1 and 2 only. A valid input seen in battery-powered mode selects input-powered on the next cycle. On losing the input, input-powered falls to battery-powered if the battery is above the over-discharge level, and otherwise to over-discharge-off.
- R9: The measurement switch is closed only when its enable is high, the mode is 1 or 2, no overcurrent or short is flagged, and no unrecovered over-discharge is pending.
- R10: Each deglitch timer restarts from zero whenever its condition drops out before the limit is reached.
- R11: After reset the mode is shutdown, the rail is unpowered, and the regulator and measurement switch are off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle strobe once per millisecond |
| in_ok_a | input | 1 | Input supply within its valid window |
| bat_ok_a | input | 1 | Battery above the over-discharge level |
| bat_rel_a | input | 1 | Battery above the release level |
| ovc_a | input | 1 | Discharge overcurrent flag |
| short_a | input | 1 | Supply-rail short flag |
| sd_a | input | 1 | Shutdown request |
| wake_a | input | 1 | Wake-up input |
| meas_en_a | input | 1 | Battery-measurement enable |
| mode_o | output | 2 | Current mode code |
| rail_sel | output | 2 | System rail feed select |
| reg_en | output | 1 | Regulator enable |
| meas_sw | output | 1 | Battery-measurement switch close |

## Verification
The assertions work on the synchronized flags and the timer-done wires. They assume that the comparator flags are quasi-static relative to the clock. They also assume that the release flag implies the over-discharge flag whenever a transition out of input-powered depends on both. The stimulus changes flags only at falling clock edges and then holds them for whole milliseconds. The one exception is the short flag, which is held for a few cycles. Contradictory flag pairs are used only in an off mode, where they do not drive a transition.

// File: rtl/pm_pkg.sv
package pm_pkg;

  typedef enum logic [1:0] {
    M_SHD = 2'd0,
    M_IN  = 2'd1,
    M_BAT = 2'd2,
    M_ODC = 2'd3
  } pm_mode_e;

  localparam logic [1:0] RAIL_OFF = 2'b00;
  localparam logic [1:0] RAIL_IN  = 2'b01;
  localparam logic [1:0] RAIL_BAT = 2'b10;

  // positions in the synchronized flag vector
  localparam int F_IN  = 0;
  localparam int F_BOK = 1;
  localparam int F_REL = 2;
  localparam int F_OVC = 3;
  localparam int F_SHT = 4;
  localparam int F_SD  = 5;
  localparam int F_WK  = 6;
  localparam int F_MEN = 7;
  localparam int NFLAG = 8;

  // positions in the deglitch-done vector
  localparam int D_IN  = 0;
  localparam int D_WK  = 1;
  localparam int D_ODC = 2;
  localparam int D_OVC = 3;
  localparam int NDG   = 4;

  function automatic logic [1:0] rail_of(pm_mode_e m);
    case (m)
      M_IN:    return RAIL_IN;
      M_BAT:   return RAIL_BAT;
      default: return RAIL_OFF;
    endcase
  endfunction

  function automatic logic is_on(pm_mode_e m);
    return (m == M_IN) || (m == M_BAT);
  endfunction

endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_a,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d_a;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/pm_deglitch.sv
module pm_deglitch #(
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cond,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!cond)             cnt <= '0;
    else if (tick && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign done = cond && (cnt == LIM);
endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
  import pm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_ok,
  input  logic     bat_ok,
  input  logic     bat_rel,
  input  logic     sd,
  input  logic     wake,
  input  logic     shrt,
  input  logic     in_done,
  input  logic     wake_done,
  input  logic     ovc_done,
  input  logic     odc_done,
  output pm_mode_e mode,
  output logic     odc_latch
);
  pm_mode_e nxt;

  always_comb begin
    nxt = mode;
    case (mode)
      M_SHD, M_ODC: begin
        if (in_done)                  nxt = M_IN;
        else if (wake_done && bat_rel) nxt = M_BAT;
      end
      M_IN: begin
        if (!in_ok) nxt = (odc_latch || !bat_ok) ? M_ODC : M_BAT;
      end
      M_BAT: begin
        if (in_ok)            nxt = M_IN;
        else if (shrt)        nxt = M_SHD;
        else if (ovc_done)    nxt = M_SHD;
        else if (odc_done)    nxt = M_ODC;
        else if (sd && !wake) nxt = M_SHD;
      end
      default: nxt = M_SHD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= M_SHD;
      odc_latch <= 1'b0;
    end else begin
      mode <= nxt;
      if (mode == M_ODC) odc_latch <= 1'b1;
      else if (bat_rel)  odc_latch <= 1'b0;
    end
  end
endmodule

// File: rtl/pm_sup.sv
module pm_sup
  import pm_pkg::*;
#(
  parameter int IN_HOLD_MS   = 240,
  parameter int WAKE_HOLD_MS = 1200,
  parameter int ODC_HOLD_MS  = 60,
  parameter int OVC_HOLD_MS  = 10,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       in_ok_a,
  input  logic       bat_ok_a,
  input  logic       bat_rel_a,
  input  logic       ovc_a,
  input  logic       short_a,
  input  logic       sd_a,
  input  logic       wake_a,
  input  logic       meas_en_a,
  output logic [1:0] mode_o,
  output logic [1:0] rail_sel,
  output logic       reg_en,
  output logic       meas_sw
);
  localparam int LIMS [NDG] = '{IN_HOLD_MS, WAKE_HOLD_MS, ODC_HOLD_MS, OVC_HOLD_MS};

  logic [NFLAG-1:0] flg_a, flg_s;
  logic [NDG-1:0]   dg_cond, dg_done;
  pm_mode_e         mode;
  logic             odc_latch;
  logic             off_mode, bat_mode;

  assign flg_a = {meas_en_a, wake_a, sd_a, short_a, ovc_a, bat_rel_a, bat_ok_a, in_ok_a};

  pm_sync #(.W(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_a(flg_a), .q(flg_s)
  );

  assign off_mode = (mode == M_SHD) || (mode == M_ODC);
  assign bat_mode = (mode == M_BAT);

  assign dg_cond[D_IN]  = off_mode && flg_s[F_IN];
  assign dg_cond[D_WK]  = off_mode && flg_s[F_WK] && !flg_s[F_IN];
  assign dg_cond[D_ODC] = bat_mode && !flg_s[F_BOK];
  assign dg_cond[D_OVC] = bat_mode && flg_s[F_OVC];

  for (genvar g = 0; g < NDG; g++) begin : g_dg
    pm_deglitch #(.LIMIT(LIMS[g])) u_dg (
      .clk(clk), .rst_n(rst_n), .tick(ms_tick),
      .cond(dg_cond[g]), .done(dg_done[g])
    );
  end

  pm_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .in_ok(flg_s[F_IN]), .bat_ok(flg_s[F_BOK]), .bat_rel(flg_s[F_REL]),
    .sd(flg_s[F_SD]), .wake(flg_s[F_WK]), .shrt(flg_s[F_SHT]),
    .in_done(dg_done[D_IN]), .wake_done(dg_done[D_WK]),
    .ovc_done(dg_done[D_OVC]), .odc_done(dg_done[D_ODC]),
    .mode(mode), .odc_latch(odc_latch)
  );

  assign mode_o   = mode;
  assign rail_sel = rail_of(mode);
  assign reg_en   = is_on(mode);
  assign meas_sw  = flg_s[F_MEN] && is_on(mode) && !flg_s[F_OVC]
                    && !flg_s[F_SHT] && !odc_latch;
endmodule

// File: rtl/pm_sup_chk.sv
module pm_sup_chk
  import pm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [NFLAG-1:0] flg_s,
  input logic [NDG-1:0]   dg_done,
  input logic [1:0]       mode_o,
  input logic             odc_latch,
  input logic [1:0]       rail_sel,
  input logic             meas_sw
);
  logic in_m, bat_m, shd_m, odc_m;
  assign in_m  = mode_o == 2'd1;
  assign bat_m = mode_o == 2'd2;
  assign shd_m = mode_o == 2'd0;
  assign odc_m = mode_o == 2'd3;

  // R1
  sd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_m |=> !shd_m);

  // R2
  in_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_m) |-> $past(flg_s[F_IN]));

  // R3
  sd_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bat_m && flg_s[F_SD] && !flg_s[F_WK] && !flg_s[F_IN] && !dg_done[D_ODC]) |=> shd_m);

  // R4
  odc_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bat_m && dg_done[D_ODC] && !flg_s[F_IN] && !flg_s[F_SHT] && !dg_done[D_OVC]) |=> odc_m);

  // R5
  odc_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_m && odc_latch && !flg_s[F_IN]) |=> odc_m);

  // R6
  ovc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bat_m && dg_done[D_OVC] && !flg_s[F_IN]) |=> shd_m);

  // R7
  short_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bat_m && flg_s[F_SHT] && !flg_s[F_IN]) |=> shd_m);

  // R8
  in_takeover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bat_m && flg_s[F_IN]) |=> in_m);

  // R9
  meas_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_sw |-> (rail_sel != RAIL_OFF));

  // R10
  in_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shd_m && !flg_s[F_IN]) |=> !dg_done[D_IN]);
endmodule

bind pm_sup pm_sup_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flg_s(flg_s), .dg_done(dg_done),
  .mode_o(mode_o), .odc_latch(odc_latch), .rail_sel(rail_sel), .meas_sw(meas_sw)
);

// File: tb/tb_pm_sup.sv
module tb_pm_sup;
  localparam int TDIV = 4;

  typedef struct packed {
    logic in_ok, bat_ok, bat_rel, ovc, shrt, sd, wake, men;
    int        hold;
    logic [1:0] mode;
    logic      meas;
    int        req;
  } step_t;

  localparam int NSTEP = 22;
  localparam step_t TBL [NSTEP] = '{
    '{1,1,1,0,0,0,0,1, 250, 2'd1,1, 2},  // R2 input qualifies
    '{1,1,1,0,0,1,0,1,  20, 2'd1,1, 1},  // R1 request ignored with input
    '{0,1,1,0,0,0,0,1,   5, 2'd2,1, 8},  // R8 falls to battery
    '{0,1,1,0,0,1,0,1,   5, 2'd0,0, 1},  // R1 request shuts down
    '{0,1,1,0,0,1,1,1,1250, 2'd2,1, 3},  // R3 on during pulse
    '{0,1,1,0,0,1,0,1,   5, 2'd0,0, 3},  // R3 off at pulse end
    '{0,1,1,0,0,0,1,1,1250, 2'd2,1, 2},  // R2 wake qualifies
    '{0,1,1,1,0,0,0,1,  20, 2'd0,0, 6},  // R6 overcurrent off
    '{1,1,1,0,0,0,0,1, 250, 2'd1,1, 6},  // R6 input restores
    '{0,1,1,0,0,0,0,1,   5, 2'd2,1, 8},  // R8
    '{0,0,0,0,0,0,0,1,  70, 2'd3,0, 4},  // R4 over-discharge
    '{1,0,0,0,0,0,0,1, 250, 2'd1,0, 5},  // R5 input during od
    '{0,0,0,0,0,0,0,1,   5, 2'd3,0, 5},  // R5 back to od
    '{1,1,0,0,0,0,0,1, 250, 2'd1,0, 5},  // R5
    '{0,1,0,0,0,0,0,1,   5, 2'd3,0, 5},  // R5 above od, below release
    '{1,1,1,0,0,0,0,1, 250, 2'd1,1, 5},  // R5 recovered
    '{0,1,1,0,0,0,0,1,   5, 2'd2,1, 5},  // R5 now battery
    '{0,1,1,0,0,0,0,0,   2, 2'd2,0, 9},  // R9 enable low
    '{0,1,1,0,0,1,0,1,   5, 2'd0,0, 1},  // R1
    '{0,1,0,0,0,0,1,1,1300, 2'd0,0, 2},  // R2 wake without release
    '{1,1,1,0,0,0,0,1, 250, 2'd1,1, 8},  // R8
    '{0,0,0,0,0,0,0,1,   5, 2'd3,0, 8}   // R8 no battery, unpowered
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] tdiv;
  logic ms_tick;
  logic in_ok_a = 0, bat_ok_a = 1, bat_rel_a = 1, ovc_a = 0, short_a = 0;
  logic sd_a = 0, wake_a = 0, meas_en_a = 1;
  logic [1:0] mode_o, rail_sel;
  logic reg_en, meas_sw;
  int ncmp = 0;
  int nbad = 0;

  always #10 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tdiv <= '0;
    else        tdiv <= tdiv + 1'b1;
  end
  assign ms_tick = (tdiv == 2'd3);

  pm_sup dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
    .in_ok_a(in_ok_a), .bat_ok_a(bat_ok_a), .bat_rel_a(bat_rel_a),
    .ovc_a(ovc_a), .short_a(short_a), .sd_a(sd_a), .wake_a(wake_a),
    .meas_en_a(meas_en_a), .mode_o(mode_o), .rail_sel(rail_sel),
    .reg_en(reg_en), .meas_sw(meas_sw)
  );

  function automatic logic [1:0] exp_rail(logic [1:0] m);
    if (m == 2'd1) return 2'b01;
    if (m == 2'd2) return 2'b10;
    return 2'b00;
  endfunction

  task automatic wait_ms(int n);
    repeat (n * TDIV) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [1:0] em, logic emeas);
    logic [1:0] er;
    logic ereg;
    er   = exp_rail(em);
    ereg = (em == 2'd1) || (em == 2'd2);
    ncmp++;
    if (mode_o !== em || rail_sel !== er || reg_en !== ereg || meas_sw !== emeas) begin
      nbad++;
      $display("FAIL %s: mode=%0d rail=%b reg=%b meas=%b expected mode=%0d rail=%b reg=%b meas=%b",
               tag, mode_o, rail_sel, reg_en, meas_sw, em, er, ereg, emeas);
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: run did not end, expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wait_ms(3);
    chk("R11 reset state", 2'd0, 1'b0);

    for (int i = 0; i < NSTEP; i++) begin
      in_ok_a = TBL[i].in_ok; bat_ok_a = TBL[i].bat_ok; bat_rel_a = TBL[i].bat_rel;
      ovc_a = TBL[i].ovc; short_a = TBL[i].shrt; sd_a = TBL[i].sd;
      wake_a = TBL[i].wake; meas_en_a = TBL[i].men;
      wait_ms(TBL[i].hold);
      chk($sformatf("R%0d table step %0d", TBL[i].req, i), TBL[i].mode, TBL[i].meas);
    end

    // R10: input timer restarts after a dropout (starts in over-discharge-off)
    bat_ok_a = 1; bat_rel_a = 1;
    in_ok_a = 1; wait_ms(200);
    in_ok_a = 0; wait_ms(2);
    in_ok_a = 1; wait_ms(200);
    chk("R10 input dropout restarts timer", 2'd3, 1'b0);
    wait_ms(50);
    chk("R10 input qualifies after restart", 2'd1, 1'b1);
    in_ok_a = 0; wait_ms(5);
    chk("R8 battery after input loss", 2'd2, 1'b1);

    // R6 / R9: short overcurrent opens meas only
    ovc_a = 1; wait_ms(3);
    chk("R9 overcurrent opens meas", 2'd2, 1'b0);
    ovc_a = 0; wait_ms(2);
    chk("R6 short overcurrent ignored", 2'd2, 1'b1);
    ovc_a = 1; wait_ms(6);
    ovc_a = 0; wait_ms(1);
    ovc_a = 1; wait_ms(6);
    chk("R10 overcurrent timer restarts", 2'd2, 1'b0);
    ovc_a = 0; wait_ms(1);

    // R7: short acts at once
    short_a = 1;
    repeat (4) @(negedge clk);
    chk("R7 short turns off at once", 2'd0, 1'b0);
    short_a = 0; wait_ms(2);

    // R3: wake time not counted while input valid
    wake_a = 1; in_ok_a = 1; wait_ms(200);
    in_ok_a = 0; wait_ms(1100);
    chk("R3 wake ignored with input", 2'd0, 1'b0);
    wait_ms(150);
    chk("R3 wake qualifies after input gone", 2'd2, 1'b1);

    summary();
    $finish;
  end
endmodule